// File: doc/BRIEF.md
# Address Region Access Guard

This block sits beside a bus and decides, within the same clock cycle, whether an access may proceed. Each access presents a master number, a 32-bit byte address and an access kind (read, write or instruction fetch). The guard compares the address against a set of programmable windows, sixteen by default, all at the same time. Each window has its own permission bits for every master. An access is allowed when at least one enabled window contains the address and grants the requested kind to that master. Window bounds work on 32-byte blocks, so the five low address bits play no part in the comparison.

Software sets up the windows through a simple word-addressed register port. The first access that is refused has its address, master and kind latched into error registers, and a sticky error flag is raised. Later refusals leave the latched record alone until software clears the flag.

The access port uses a valid signal only. The answer is combinational in the same cycle, so the port never applies back-pressure and has no ready signal. The register port is plain: a write strobe and an address, with read data returned combinationally.

Top module: `mem_guard`

## Requirements
- R1: After reset every window is disabled and the error flag is 0, so every access is refused and window control words read back as 0.
- R2: A window matches when start <= addr[31:5] <= end, with both bounds inclusive. Address bits [4:0] are ignored in the access address and in written bounds.
- R3: The access kind is encoded as 0 = read, 1 = write, 2 = fetch, and 3 is reserved and always refused. In a window control word, bits [3m+2:3m] belong to master m, with bit 3m = read, 3m+1 = write and 3m+2 = fetch.
- R4: Control word bit 12 (bit 3*NMST) enables the window. A disabled window grants nothing, whatever its permission bits say.
- R5: When windows overlap, the access is allowed if any enabled matching window grants it.
- R6: acc_allow is a same-cycle function of the access inputs and is 0 whenever acc_valid is 0.
- R7: A refused valid access while the flag is clear sets the flag at the next clock edge. The same edge latches the address into the error address word (index 65) and latches {kind, master} into the error info word (index 66: master in bits [1:0], kind in bits [3:2]).
- R8: While the flag is set, later refusals do not change the latched address or info.
- R9: Writing a 1 in bit 0 of the status word (index 64, which reads back the flag in bit 0) clears the flag. If a refusal arrives in the same cycle, the refusal is latched and the flag stays set.
- R10: Register word index r*4+0 holds the start bound of window r, r*4+1 holds its end bound, and r*4+2 holds its control word. Bounds read back with bits [4:0] as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_master | input | 2 | Master number of the access |
| acc_addr | input | 32 | Byte address of the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| acc_allow | output | 1 | Access permitted (same cycle) |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 7 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_idx |

## Verification
The bench builds the guard with its default parameters: sixteen windows, four masters and a 32-bit address. With these values, window 0 and window 15 can both be exercised, which covers the lowest and highest entries of the register map. Every permission field from bit 0 up to the enable bit at position 12 is reachable. The tests probe the inclusive edges of a window to the byte, overlapping windows with different grants, the reserved access kind, and the cycle in which a flag clear and a new refusal meet.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int MG_BLK_LSB = 5;
  typedef enum logic [1:0] {
    KIND_RD  = 2'd0,
    KIND_WR  = 2'd1,
    KIND_EX  = 2'd2,
    KIND_RSV = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/mg_window.sv
module mg_window #(
  parameter int AW   = 32,
  parameter int NMST = 4,
  parameter int MW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_word,
  input  logic [31:0]   wdata,
  input  logic [1:0]    rd_word,
  output logic [31:0]   rdata,
  input  logic [AW-1:mg_pkg::MG_BLK_LSB] blk,
  input  logic [MW-1:0] master,
  input  logic [1:0]    kind,
  output logic          enabled,
  output logic          grant
);
  localparam int BW    = AW - mg_pkg::MG_BLK_LSB;
  localparam int PERMW = 3 * NMST;

  logic [BW-1:0]    lo_q, hi_q;
  logic [PERMW-1:0] perm_q;
  logic             en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      perm_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_word)
        2'd0: lo_q <= wdata[AW-1:mg_pkg::MG_BLK_LSB];
        2'd1: hi_q <= wdata[AW-1:mg_pkg::MG_BLK_LSB];
        2'd2: begin
          perm_q <= wdata[PERMW-1:0];
          en_q   <= wdata[PERMW];
        end
        default: ;
      endcase
    end
  end

  logic bit_ok;
  always_comb begin
    bit_ok = 1'b0;
    for (int m = 0; m < NMST; m++)
      for (int b = 0; b < 3; b++)
        if (master == MW'(m) && kind == 2'(b))
          bit_ok = perm_q[m*3+b];
  end

  assign enabled = en_q;
  assign grant   = en_q && (blk >= lo_q) && (blk <= hi_q) && bit_ok;

  always_comb begin
    rdata = '0;
    case (rd_word)
      2'd0: rdata[AW-1:mg_pkg::MG_BLK_LSB] = lo_q;
      2'd1: rdata[AW-1:mg_pkg::MG_BLK_LSB] = hi_q;
      2'd2: rdata[PERMW:0] = {en_q, perm_q};
      default: ;
    endcase
  end
endmodule

// File: rtl/mg_errlog.sv
module mg_errlog #(
  parameter int AW = 32,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          refuse,
  input  logic [AW-1:0] addr,
  input  logic [MW-1:0] master,
  input  logic [1:0]    kind,
  input  logic          clr,
  output logic          flag,
  output logic [AW-1:0] e_addr,
  output logic [MW-1:0] e_master,
  output logic [1:0]    e_kind
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      e_addr   <= '0;
      e_master <= '0;
      e_kind   <= '0;
    end else if (refuse && (!flag || clr)) begin
      flag     <= 1'b1;
      e_addr   <= addr;
      e_master <= master;
      e_kind   <= kind;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse && !flag) |=> (flag && e_addr == $past(addr) && e_master == $past(master)));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> ($stable(e_addr) && $stable(e_kind) && $stable(e_master)));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !refuse) |=> !flag);
endmodule

// File: rtl/mem_guard.sv
module mem_guard #(
  parameter int NREG = 16,
  parameter int NMST = 4,
  parameter int AW   = 32,
  parameter int MW   = $clog2(NMST),
  parameter int CIW  = $clog2(NREG) + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [MW-1:0] acc_master,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_kind,
  output logic          acc_allow,
  input  logic          cfg_we,
  input  logic [CIW-1:0] cfg_idx,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata
);
  localparam int RIW = $clog2(NREG);

  logic              in_err_space;
  logic [RIW-1:0]    win_sel;
  logic [1:0]        word_sel;
  logic [NREG-1:0]   grant_vec, en_vec;
  logic [31:0]       win_rd [NREG];

  assign in_err_space = cfg_idx[CIW-1];
  assign win_sel      = cfg_idx[RIW+1:2];
  assign word_sel     = cfg_idx[1:0];

  for (genvar r = 0; r < NREG; r++) begin : g_win
    mg_window #(.AW(AW), .NMST(NMST), .MW(MW)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && !in_err_space && win_sel == RIW'(r)),
      .wr_word (word_sel),
      .wdata   (cfg_wdata),
      .rd_word (word_sel),
      .rdata   (win_rd[r]),
      .blk     (acc_addr[AW-1:mg_pkg::MG_BLK_LSB]),
      .master  (acc_master),
      .kind    (acc_kind),
      .enabled (en_vec[r]),
      .grant   (grant_vec[r])
    );
  end

  assign acc_allow = acc_valid && (|grant_vec);

  logic          flag, clr;
  logic [AW-1:0] e_addr;
  logic [MW-1:0] e_master;
  logic [1:0]    e_kind;

  assign clr = cfg_we && in_err_space && word_sel == 2'd0 && cfg_wdata[0];

  mg_errlog #(.AW(AW), .MW(MW)) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .refuse   (acc_valid && !acc_allow),
    .addr     (acc_addr),
    .master   (acc_master),
    .kind     (acc_kind),
    .clr      (clr),
    .flag     (flag),
    .e_addr   (e_addr),
    .e_master (e_master),
    .e_kind   (e_kind)
  );

  always_comb begin
    cfg_rdata = '0;
    if (!in_err_space) begin
      cfg_rdata = win_rd[win_sel];
    end else begin
      case (word_sel)
        2'd0: cfg_rdata[0] = flag;
        2'd1: cfg_rdata[AW-1:0] = e_addr;
        2'd2: cfg_rdata[MW+1:0] = {e_kind, e_master};
        default: ;
      endcase
    end
  end

  assert_rsv_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == mg_pkg::KIND_RSV) |-> !acc_allow);
  assert_none_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && en_vec == '0) |-> !acc_allow);
endmodule

// File: tb/sim_mem_guard.sv
module sim_mem_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_master = '0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_allow;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mem_guard u0 (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_idx = 7'(idx); cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
    @(negedge clk);
    cfg_idx = 7'(idx);
    #2 chk(req, cfg_rdata, exp);
  endtask

  task automatic probe(input string req, input int m, input logic [31:0] a, input int k, input logic exp);
    @(negedge clk);
    acc_valid = 1'b1; acc_master = 2'(m); acc_addr = a; acc_kind = 2'(k);
    #2 chk(req, {31'd0, acc_allow}, {31'd0, exp});
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic set_win(input int r, input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] ctl);
    wr(r*4, lo); wr(r*4+1, hi); wr(r*4+2, ctl);
  endtask

  task automatic t_reset;
    rd_chk("R1 flag", 64, 32'd0);
    rd_chk("R1 ctl0", 2, 32'd0);
    rd_chk("R1 ctl15", 62, 32'd0);
    probe("R1 refuse", 0, 32'h0000_0000, 0, 1'b0);
    wr(64, 32'd1);
  endtask

  task automatic t_readback;
    set_win(3, 32'h1000_0047, 32'h2000_001F, 32'h0000_1ABC);
    rd_chk("R10 start", 12, 32'h1000_0040);
    rd_chk("R10 end", 13, 32'h2000_0000);
    rd_chk("R10 ctl", 14, 32'h0000_1ABC);
    set_win(3, 0, 0, 0);
  endtask

  task automatic t_bounds;
    set_win(0, 32'h0000_1000, 32'h0000_1FE0, 32'h0000_1001);
    probe("R2 low edge", 0, 32'h0000_1000, 0, 1'b1);
    probe("R2 below", 0, 32'h0000_0FFF, 0, 1'b0);
    probe("R2 high edge low bits", 0, 32'h0000_1FFF, 0, 1'b1);
    probe("R2 above", 0, 32'h0000_2000, 0, 1'b0);
    wr(64, 32'd1);
  endtask

  task automatic t_perm;
    set_win(0, 32'h0000_1000, 32'h0000_1FE0, 32'h0000_1F11);
    probe("R3 m0 rd", 0, 32'h0000_1100, 0, 1'b1);
    probe("R3 m0 wr", 0, 32'h0000_1100, 1, 1'b0);
    probe("R3 m1 wr", 1, 32'h0000_1100, 1, 1'b1);
    probe("R3 m1 rd", 1, 32'h0000_1100, 0, 1'b0);
    probe("R3 m2 ex", 2, 32'h0000_1100, 2, 1'b1);
    probe("R3 m2 wr", 2, 32'h0000_1100, 1, 1'b0);
    probe("R3 m3 ex", 3, 32'h0000_1100, 2, 1'b1);
    probe("R3 m3 rsv", 3, 32'h0000_1100, 3, 1'b0);
    wr(64, 32'd1);
  endtask

  task automatic t_enable;
    wr(2, 32'h0000_0FFF);
    probe("R4 disabled", 0, 32'h0000_1100, 0, 1'b0);
    wr(2, 32'h0000_1FFF);
    probe("R4 enabled", 0, 32'h0000_1100, 0, 1'b1);
    wr(2, 32'h0);
    wr(64, 32'd1);
  endtask

  task automatic t_overlap;
    set_win(5, 32'h0000_4000, 32'h0000_4FE0, 32'h0000_1001);
    set_win(15, 32'h0000_4800, 32'h0000_5FE0, 32'h0000_1002);
    probe("R5 both wr", 0, 32'h0000_4900, 1, 1'b1);
    probe("R5 both rd", 0, 32'h0000_4900, 0, 1'b1);
    probe("R5 only5 wr", 0, 32'h0000_4100, 1, 1'b0);
    probe("R5 only15 rd", 0, 32'h0000_5100, 0, 1'b0);
    wr(64, 32'd1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    acc_valid = 1'b0; acc_master = 2'd0; acc_addr = 32'h0000_4900; acc_kind = 2'd0;
    #2 chk("R6 idle low", {31'd0, acc_allow}, 32'd0);
    acc_valid = 1'b1;
    #1 chk("R6 same cycle", {31'd0, acc_allow}, 32'd1);
    acc_valid = 1'b0;
  endtask

  task automatic t_capture;
    wr(64, 32'd1);
    rd_chk("R9 cleared", 64, 32'd0);
    probe("R7 refuse", 2, 32'h7777_0004, 1, 1'b0);
    rd_chk("R7 flag", 64, 32'd1);
    rd_chk("R7 addr", 65, 32'h7777_0004);
    rd_chk("R7 info", 66, 32'd6);
    probe("R8 second refuse", 1, 32'h0000_1234, 2, 1'b0);
    rd_chk("R8 addr kept", 65, 32'h7777_0004);
    rd_chk("R8 info kept", 66, 32'd6);
    wr(64, 32'd1);
    rd_chk("R9 clear", 64, 32'd0);
    probe("R9 refuse A", 3, 32'h0000_AAA0, 0, 1'b0);
    @(negedge clk);
    cfg_idx = 7'd64; cfg_wdata = 32'd1; cfg_we = 1'b1;
    acc_valid = 1'b1; acc_master = 2'd1; acc_addr = 32'h0000_BBB8; acc_kind = 2'd2;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    rd_chk("R9 clash flag", 64, 32'd1);
    rd_chk("R9 clash addr", 65, 32'h0000_BBB8);
    rd_chk("R9 clash info", 66, 32'd9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_readback;
    t_bounds;
    t_perm;
    t_enable;
    t_overlap;
    t_idle;
    t_capture;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule